// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Resend

This block sends one byte at a time over a single shared half-duplex line to a smart card. Software writes a byte into a holding register. When transmission is enabled and the engine is free, it copies the byte into its frame register and marks the holding register empty, so the next byte can be queued at once. Each character goes out as a low start bit, eight data bits least significant first, and an even parity bit. Every bit is held for a programmable number of clock cycles.

After the parity bit the engine releases the line for two bit periods. In the middle of the first released period it samples the line. A card that rejected the character holds the line low at that point. The engine then raises an error flag, withholds the transmit-end flag, and sends the same byte again straight after the guard time. If the line stays high, the character counts as delivered: the transmit-end flag rises, and any queued byte starts immediately. Two interrupt outputs are the error flag and the transmit-end flag, each gated by its own enable.

Top module: `smartcard_tx`

## Requirements
- R1: A frame is a low start bit, then data bits 0..7 of the byte in that order, then a bit equal to the XOR of the eight data bits (even parity). Each bit lasts `etu_cycles` clocks (`etu_cycles` >= 2), and `io_oe` is 1 for exactly these ten bits.
- R2: After the parity bit, `io_oe` is 0 and `io_out` is 1 for two bit periods. No frame starts before both have elapsed.
- R3: The line is sampled once per frame, in clock `etu_cycles/2` (rounded down, counted from 0) of the first released bit period. If `io_in` is 0 there, `ers` becomes 1 on the next edge.
- R4: `irq_err` equals `ers` AND `rie_en`.
- R5: A frame with no error sample sets `tend` to 1 at the edge that ends its second released bit period. `irq_tx` equals `tend` AND `tie_en`.
- R6: A frame with an error sample does not set `tend`. The same byte is resent, starting right at the edge that ends the guard time.
- R7: Loading the frame register sets `tdre` to 1. A holding register write (`data_we`) clears both `tdre` and `tend`, and it wins over a load on the same edge. A resend leaves `tdre` unchanged.
- R8: A `stat_we` write clears `tend` when bit 0 is 0 and clears `ers` when bit 1 is 0. A 1 in either bit has no effect. A hardware set on the same edge wins over the clear.
- R9: While `tx_en` is 0, no new byte is loaded. A pending byte keeps `tdre` at 0 and the line stays released.
- R10: After reset, `tdre`=1, `tend`=1, `ers`=0, `io_oe`=0 and `io_out`=1.
- R11: If a byte is pending and `tx_en` is 1 when a frame completes without error, that byte's start bit begins on the same edge that ends the guard time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| etu_cycles | input | ETU_W | Clocks per bit, at least 2 |
| tx_en | input | 1 | Allows new bytes to be loaded |
| rie_en | input | 1 | Error interrupt enable |
| tie_en | input | 1 | Transmit-end interrupt enable |
| data_we | input | 1 | Write strobe for the holding register |
| data_wd | input | DW | Byte written to the holding register |
| stat_we | input | 1 | Status write strobe (write zero to clear) |
| stat_wd | input | 2 | Bit 0: tend, bit 1: ers |
| io_in | input | 1 | Sensed level of the shared line |
| io_out | output | 1 | Level driven when io_oe is 1 |
| io_oe | output | 1 | Drive enable for the line |
| tdre | output | 1 | Holding register empty |
| tend | output | 1 | Transmit end |
| ers | output | 1 | Error signal received |
| irq_err | output | 1 | Error interrupt request |
| irq_tx | output | 1 | Transmit-end interrupt request |

## Verification
The bench targets the following corner cases:
- The error sample in the middle of the first released bit. A sampler one cycle early or late would read the card's signal at the wrong moment.
- A rejected byte that is followed by a byte queued during its resend. A design that refreshed the frame register on a resend, or touched `tdre` then, would send the wrong data or lose the queued byte.
- Back-to-back frames after a success. A design that idled between them would break the cycle-exact comparison of the line.
- Write-zero clearing of the status flags, `tx_en` held low with data pending, and an odd bit length. The odd length exposes rounding errors in the sample point and in the bit-period count.

// File: rtl/smartcard_tx.sv
module smartcard_tx #(
  parameter int ETU_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ETU_W-1:0] etu_cycles,
  input  logic             tx_en,
  input  logic             rie_en,
  input  logic             tie_en,
  input  logic             data_we,
  input  logic [DW-1:0]    data_wd,
  input  logic             stat_we,
  input  logic [1:0]       stat_wd,
  input  logic             io_in,
  output logic             io_out,
  output logic             io_oe,
  output logic             tdre,
  output logic             tend,
  output logic             ers,
  output logic             irq_err,
  output logic             irq_tx
);
  localparam int IW = $clog2(DW + 4);
  localparam logic [IW-1:0] IDX_PAR  = IW'(DW + 1);
  localparam logic [IW-1:0] IDX_SLOT = IW'(DW + 2);
  localparam logic [IW-1:0] IDX_LAST = IW'(DW + 3);

  logic             busy;
  logic [IW-1:0]    bit_idx;
  logic [ETU_W-1:0] cnt;
  logic [DW-1:0]    tdr;
  logic [DW-1:0]    frame_q;
  logic             err_seen;

  wire bit_end   = busy && (cnt == etu_cycles - 1'b1);
  wire slot_hit  = busy && (bit_idx == IDX_SLOT) && (cnt == (etu_cycles >> 1));
  wire nack      = slot_hit && !io_in;
  wire frame_end = bit_end && (bit_idx == IDX_LAST);
  wire retry     = frame_end && err_seen;
  wire done_ok   = frame_end && !err_seen;
  wire load      = tx_en && !tdre && (!busy || done_ok);

  wire [DW-1:0] dsel = frame_q >> (bit_idx - 1'b1);

  assign io_oe   = busy && (bit_idx < IDX_SLOT);
  assign irq_err = ers && rie_en;
  assign irq_tx  = tend && tie_en;

  always_comb begin
    if (!io_oe)                  io_out = 1'b1;
    else if (bit_idx == '0)      io_out = 1'b0;
    else if (bit_idx == IDX_PAR) io_out = ^frame_q;
    else                         io_out = dsel[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      bit_idx  <= '0;
      cnt      <= '0;
      frame_q  <= '0;
      err_seen <= 1'b0;
    end else if (load) begin
      busy     <= 1'b1;
      bit_idx  <= '0;
      cnt      <= '0;
      frame_q  <= tdr;
      err_seen <= 1'b0;
    end else if (busy) begin
      cnt <= bit_end ? '0 : cnt + 1'b1;
      if (nack) err_seen <= 1'b1;
      if (bit_end) begin
        if (bit_idx == IDX_LAST) begin
          bit_idx <= '0;
          if (retry) err_seen <= 1'b0;
          else       busy     <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdr  <= '0;
      tdre <= 1'b1;
      tend <= 1'b1;
      ers  <= 1'b0;
    end else begin
      if (data_we) tdr <= data_wd;

      if (data_we)   tdre <= 1'b0;
      else if (load) tdre <= 1'b1;

      if (data_we)                      tend <= 1'b0;
      else if (done_ok)                 tend <= 1'b1;
      else if (stat_we && !stat_wd[0])  tend <= 1'b0;

      if (nack)                         ers <= 1'b1;
      else if (stat_we && !stat_wd[1])  ers <= 1'b0;
    end
  end

  AST_ERS_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ers) |-> $past(busy && bit_idx == IDX_SLOT && !io_in)); // R3
  AST_NO_TEND_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend) |-> !$past(err_seen)); // R6
  AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_oe) |=> !io_oe); // R2
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(data_we) |-> (!tdre && !tend)); // R7
  AST_LOAD_SETS_TDRE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load) && !$past(data_we)) |-> tdre); // R7
  AST_ERS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_we && !stat_wd[1]) && !$past(nack)) |-> !ers); // R8
  AST_RESEND_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    $past(retry) |-> $stable(frame_q)); // R6
endmodule

// File: tb/smartcard_tx_bench.sv
module smartcard_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] etu_cycles = 8'd8;
  logic       tx_en = 1'b0, rie_en = 1'b0, tie_en = 1'b0;
  logic       data_we = 1'b0;
  logic [7:0] data_wd = 8'h00;
  logic       stat_we = 1'b0;
  logic [1:0] stat_wd = 2'b11;
  logic       nack_drv = 1'b0;
  logic       io_in;
  logic       io_out, io_oe, tdre, tend, ers, irq_err, irq_tx;

  always #10 clk = ~clk;

  assign io_in = (io_oe ? io_out : 1'b1) & ~nack_drv;

  smartcard_tx u_smartcard_tx (
    .clk(clk), .rst_n(rst_n), .etu_cycles(etu_cycles), .tx_en(tx_en),
    .rie_en(rie_en), .tie_en(tie_en), .data_we(data_we), .data_wd(data_wd),
    .stat_we(stat_we), .stat_wd(stat_wd), .io_in(io_in), .io_out(io_out),
    .io_oe(io_oe), .tdre(tdre), .tend(tend), .ers(ers),
    .irq_err(irq_err), .irq_tx(irq_tx));

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // reference model, frame position kept as elapsed cycles
  int m_t = 0;
  bit m_busy = 0, m_err = 0, m_tdre = 1, m_tend = 1, m_ers = 0;
  logic [7:0] m_byte = 8'h00, m_tdr = 8'h00;
  bit ld, st_tend, st_ers;

  always @(posedge clk) begin
    int e;
    e = int'(etu_cycles);
    if (!rst_n) begin
      m_t = 0; m_busy = 0; m_err = 0; m_tdre = 1; m_tend = 1; m_ers = 0;
      m_byte = 8'h00; m_tdr = 8'h00;
    end else begin
      ld = 0; st_tend = 0; st_ers = 0;
      if (m_busy) begin
        if (m_t == 10*e + e/2 && nack_drv) begin m_err = 1; st_ers = 1; end
        if (m_t == 12*e - 1) begin
          if (m_err) begin m_t = 0; m_err = 0; end
          else begin
            st_tend = 1;
            if (tx_en && !m_tdre) ld = 1; else m_busy = 0;
          end
        end else m_t++;
      end else if (tx_en && !m_tdre) ld = 1;
      if (ld) begin m_byte = m_tdr; m_busy = 1; m_t = 0; m_err = 0; end
      if (data_we) begin m_tdr = data_wd; m_tdre = 0; m_tend = 0; end
      else begin
        if (ld) m_tdre = 1;
        if (st_tend) m_tend = 1;
        else if (stat_we && !stat_wd[0]) m_tend = 0;
      end
      if (st_ers) m_ers = 1;
      else if (stat_we && !stat_wd[1]) m_ers = 0;
    end
  end

  always begin
    int e, b;
    logic eo, ev;
    @(posedge clk);
    cycles++;
    #5;
    if (rst_n && !done) begin
      e  = int'(etu_cycles);
      b  = m_t / e;
      eo = m_busy && (m_t < 10*e);
      if (!eo)        ev = 1'b1;
      else if (b == 0) ev = 1'b0;
      else if (b == 9) ev = ^m_byte;
      else            ev = m_byte[b-1];
      chk("R1/R2", "io_oe", io_oe, eo);
      chk("R1/R2", "io_out", io_out, ev);
      chk("R7", "tdre", tdre, m_tdre);
      chk("R5/R6", "tend", tend, m_tend);
      chk("R3/R8", "ers", ers, m_ers);
      chk("R4", "irq_err", irq_err, m_ers & rie_en);
      chk("R5", "irq_tx", irq_tx, m_tend & tie_en);
    end
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); data_we = 1'b1; data_wd = b;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic write_stat(input logic [1:0] v);
    @(negedge clk); stat_we = 1'b1; stat_wd = v;
    @(negedge clk); stat_we = 1'b0; stat_wd = 2'b11;
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (m_busy || (!m_tdre && tx_en));
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset tdre", tdre, 1'b1);
    chk("R10", "reset tend", tend, 1'b1);
    chk("R10", "reset ers", ers, 1'b0);
    chk("R10", "reset io_oe", io_oe, 1'b0);
    chk("R10", "reset io_out", io_out, 1'b1);
    rst_n = 1'b1; rie_en = 1'b1; tie_en = 1'b1; tx_en = 1'b1;

    write_byte(8'hA5);
    wait_idle();
    chk("R5", "tend after good frame", tend, 1'b1);
    chk("R5", "irq_tx after good frame", irq_tx, 1'b1);

    // R6: rejected once, next byte queued during resend
    nack_drv = 1'b1;
    write_byte(8'h01);
    do @(negedge clk); while (!ers);
    chk("R3", "ers after nack", ers, 1'b1);
    chk("R4", "irq_err after nack", irq_err, 1'b1);
    chk("R6", "tend withheld", tend, 1'b0);
    nack_drv = 1'b0;
    write_byte(8'h3C);
    repeat (30) @(negedge clk);
    chk("R7", "tdre kept through resend", tdre, 1'b0);
    wait_idle();
    chk("R11", "queued byte sent, tend", tend, 1'b1);

    // R8: write-zero clears
    write_stat(2'b10);
    chk("R8", "tend cleared", tend, 1'b0);
    chk("R8", "ers kept by 1", ers, 1'b1);
    write_stat(2'b01);
    chk("R8", "ers cleared", ers, 1'b0);
    chk("R4", "irq_err low", irq_err, 1'b0);

    // R9: disabled with data pending
    tx_en = 1'b0;
    write_byte(8'h96);
    repeat (50) @(negedge clk);
    chk("R9", "no drive while disabled", io_oe, 1'b0);
    chk("R9", "tdre still 0", tdre, 1'b0);
    tx_en = 1'b1;
    wait_idle();

    // odd bit length, rejected twice
    etu_cycles = 8'd5;
    nack_drv = 1'b1;
    write_byte(8'hFF);
    do @(negedge clk); while (!ers);
    write_stat(2'b01);
    do @(negedge clk); while (!ers);
    nack_drv = 1'b0;
    wait_idle();
    chk("R6", "tend after final resend", tend, 1'b1);

    write_byte(8'h80);
    write_byte(8'h7E);
    wait_idle();
    chk("R1", "line released at end", io_oe, 1'b0);
    finish_run();
  end

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule